// File: doc/BRIEF.md
# Predicate and Status-Flag Unit

This block sits in the execute stage of a 32-bit core that has two instruction states. Each instruction arrives with the current ALU flags, the shifter carry, the processor mode and the saved status flags of that mode. The block decides whether the instruction really executes or passes as a no-operation. It keeps the live N, Z, C, V flags and updates them from the result only when the instruction is allowed to set flags. When a flag-setting instruction writes the program counter, the block raises a request to copy the saved status back into the live status.

Instructions enter on a valid/ready stream and leave one cycle later on a second valid/ready stream. The block takes a beat when `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or the sink is taking the current output that cycle, so a stalled sink stalls the source in the same cycle. While `out_valid` is high and `out_ready` is low, the output payload does not change. The flags are committed when a beat is accepted, so the beat right behind it is tested against the updated flags.

Top module: `cond_flag_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `flags_nzcv` is 0000. The flag order is [3]=N, [2]=Z, [1]=C, [0]=V.
- R2: In the 32-bit state the condition is `in_instr[31:28]`. The codes are: 0000 Z, 0001 !Z, 0010 C, 0011 !C, 0100 N, 0101 !N, 0110 V, 0111 !V, 1000 C&!Z, 1001 !C|Z, 1010 N==V, 1011 N!=V, 1100 !Z&(N==V), 1101 Z|(N!=V), 1110 always and 1111 never. `out_exec` carries the result, tested against the flags held before the beat.
- R3: A beat whose condition fails gives `out_exec`=0 and `out_restore`=0, and it leaves `flags_nzcv` unchanged.
- R4: In the 32-bit state, a beat with the S bit (`in_instr[20]`) clear, or with `in_dp`=0, leaves the flags unchanged.
- R5: An executing 32-bit data-processing beat with S set, `in_dp`=1, `in_logical`=0 and a destination `in_instr[15:12]` other than 15 loads the flags from `alu_nzcv`.
- R6: The same beat with `in_logical`=1 takes N and Z from `alu_nzcv`, takes C from `shift_carry` and keeps V.
- R7: An executing 32-bit data-processing beat with S set and destination 15, in a mode other than user (`mode`=10000), gives `out_restore`=1 and loads the flags from `saved_nzcv`.
- R8: The same beat in user mode gives `out_restore`=0 and leaves the flags unchanged.
- R9: In the compressed state (`in_thumb`=1) with `in_tcbr`=0, `out_exec` is 1 whatever bits 31:28 hold.
- R10: In the compressed state with `in_tcbr`=1, the condition comes from `in_instr[11:8]` and uses the R2 table.
- R11: In the compressed state, a beat with `in_dp`=1 updates the flags as in R5 and R6, ignoring bit 20 and the destination field, and it never requests a restore.
- R12: `in_ready` = !`out_valid` | `out_ready`. The output payload holds while it is stalled, and the flags change only on an accepted beat.
- R13: A beat accepted in the cycle right after a flag-setting beat is tested against the flags that beat wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_instr | input | 32 | Instruction word |
| in_thumb | input | 1 | Compressed instruction state |
| in_tcbr | input | 1 | Compressed conditional branch |
| in_dp | input | 1 | Data-processing instruction |
| in_logical | input | 1 | Logical operation (carry from shifter) |
| alu_nzcv | input | 4 | Result flags from the ALU |
| shift_carry | input | 1 | Shifter carry-out |
| mode | input | 5 | Current processor mode |
| saved_nzcv | input | 4 | Saved status flags of the current mode |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Sink takes the output beat |
| out_exec | output | 1 | Instruction executes (0 means no-operation) |
| out_restore | output | 1 | Copy saved status to live status |
| flags_nzcv | output | 4 | Live flags |

## Verification
The hardest case to reach is a predicate that depends on flags written by the beat just before it, with every condition code tested against every flag pattern. The stimulus gets there with a pair of back-to-back beats. The first is an always-executing arithmetic beat that loads a chosen flag pattern, and the second probes one condition code. This is repeated for all 256 pairs. The restore path, the user-mode case and stalls are then covered by directed beats and by a long random phase in which the sink drops `out_ready` at random.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  typedef enum logic [2:0] {
    PB_ZSET  = 3'd0,
    PB_CSET  = 3'd1,
    PB_NSET  = 3'd2,
    PB_VSET  = 3'd3,
    PB_HIGH  = 3'd4,
    PB_SGE   = 3'd5,
    PB_SGT   = 3'd6,
    PB_TRUE  = 3'd7
  } pred_base_e;
endpackage

// File: rtl/cfu_cond_eval.sv
module cfu_cond_eval
  import cfu_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic [CW-1:0] cond,
  input  nzcv_t         flags,
  output logic          pass
);
  localparam int NBASE = 1 << (CW - 1);

  logic [NBASE-1:0] base;
  logic             sge;

  // Each code pair shares a base predicate; the low code bit inverts it.
  // The always-pair therefore yields always (even) and never (odd).
  always_comb begin
    sge            = (flags.n == flags.v);
    base           = '0;
    base[PB_ZSET]  = flags.z;
    base[PB_CSET]  = flags.c;
    base[PB_NSET]  = flags.n;
    base[PB_VSET]  = flags.v;
    base[PB_HIGH]  = flags.c & ~flags.z;
    base[PB_SGE]   = sge;
    base[PB_SGT]   = ~flags.z & sge;
    base[PB_TRUE]  = 1'b1;
  end

  assign pass = base[cond[CW-1:1]] ^ cond[0];
endmodule

// File: rtl/cfu_flag_next.sv
module cfu_flag_next
  import cfu_pkg::*;
(
  input  nzcv_t cur,
  input  nzcv_t alu,
  input  logic  shc,
  input  nzcv_t saved,
  input  logic  logical,
  input  logic  write_en,
  input  logic  restore_en,
  output nzcv_t nxt
);
  always_comb begin
    nxt = cur;
    if (restore_en) begin
      nxt = saved;
    end else if (write_en) begin
      nxt.n = alu.n;
      nxt.z = alu.z;
      nxt.c = logical ? shc : alu.c;
      nxt.v = logical ? cur.v : alu.v;
    end
  end
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
  import cfu_pkg::*;
#(
  parameter int                 INSTR_W   = 32,
  parameter int                 CW        = 4,
  parameter int                 COND_LSB  = 28,
  parameter int                 TCOND_LSB = 8,
  parameter int                 S_BIT     = 20,
  parameter int                 RD_LSB    = 12,
  parameter int                 RD_W      = 4,
  parameter int                 MODE_W    = 5,
  parameter logic [MODE_W-1:0]  USER_MODE = 5'b10000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [INSTR_W-1:0] in_instr,
  input  logic               in_thumb,
  input  logic               in_tcbr,
  input  logic               in_dp,
  input  logic               in_logical,
  input  logic [3:0]         alu_nzcv,
  input  logic               shift_carry,
  input  logic [MODE_W-1:0]  mode,
  input  logic [3:0]         saved_nzcv,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_exec,
  output logic               out_restore,
  output logic [3:0]         flags_nzcv
);
  localparam logic [RD_W-1:0] PC_IDX = {RD_W{1'b1}};

  nzcv_t          flags_q, flags_d;
  logic           ov_q, ox_q, or_q;
  logic           accept;
  logic [CW-1:0]  sel_cond;
  logic           pass, bypass, exec;
  logic           s_eff, pc_dst, want_flags, do_restore, do_write, priv;
  logic           unused_instr;

  assign unused_instr = ^in_instr;

  assign in_ready = ~ov_q | out_ready;
  assign accept   = in_valid & in_ready;

  // Condition source depends on the instruction state.
  assign sel_cond = in_thumb ? in_instr[TCOND_LSB +: CW] : in_instr[COND_LSB +: CW];
  assign bypass   = in_thumb & ~in_tcbr;

  cfu_cond_eval #(.CW(CW)) u_cond (
    .cond  (sel_cond),
    .flags (flags_q),
    .pass  (pass)
  );

  assign exec       = bypass | pass;
  assign s_eff      = in_thumb | in_instr[S_BIT];
  assign pc_dst     = ~in_thumb & (in_instr[RD_LSB +: RD_W] == PC_IDX);
  assign priv       = (mode != USER_MODE);
  assign want_flags = exec & in_dp & s_eff;
  assign do_restore = want_flags & pc_dst & priv;
  assign do_write   = want_flags & ~pc_dst;

  cfu_flag_next u_next (
    .cur        (flags_q),
    .alu        (nzcv_t'(alu_nzcv)),
    .shc        (shift_carry),
    .saved      (nzcv_t'(saved_nzcv)),
    .logical    (in_logical),
    .write_en   (do_write),
    .restore_en (do_restore),
    .nxt        (flags_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      ov_q    <= 1'b0;
      ox_q    <= 1'b0;
      or_q    <= 1'b0;
    end else if (accept) begin
      flags_q <= flags_d;
      ov_q    <= 1'b1;
      ox_q    <= exec;
      or_q    <= do_restore;
    end else if (out_ready) begin
      ov_q    <= 1'b0;
    end
  end

  assign out_valid   = ov_q;
  assign out_exec    = ox_q;
  assign out_restore = or_q;
  assign flags_nzcv  = flags_q;
endmodule

// File: rtl/cond_flag_unit_chk.sv
module cond_flag_unit_chk #(
  parameter int                MODE_W    = 5,
  parameter logic [MODE_W-1:0] USER_MODE = 5'b10000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_thumb,
  input logic              in_tcbr,
  input logic [MODE_W-1:0] mode,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_exec,
  input logic              out_restore,
  input logic [3:0]        flags_nzcv
);
  assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_exec) && $stable(out_restore));

  assert_stall_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_idle_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(flags_nzcv));

  assert_skip_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> (!out_exec |-> $stable(flags_nzcv) && !out_restore));

  assert_user_norestore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && mode == USER_MODE |=> !out_restore);

  assert_thumb_exec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_thumb && !in_tcbr |=> out_exec);

  assert_thumb_norestore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_thumb |=> !out_restore);
endmodule

bind cond_flag_unit cond_flag_unit_chk #(.MODE_W(MODE_W), .USER_MODE(USER_MODE)) u_chk (.*);

// File: tb/test_cond_flag_unit.sv
module test_cond_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic        in_thumb = 1'b0, in_tcbr = 1'b0, in_dp = 1'b0, in_logical = 1'b0;
  logic [3:0]  alu_nzcv = '0;
  logic        shift_carry = 1'b0;
  logic [4:0]  mode = 5'b10000;
  logic [3:0]  saved_nzcv = '0;
  logic        out_valid, out_exec, out_restore;
  logic        out_ready = 1'b1;
  logic [3:0]  flags_nzcv;

  localparam logic [4:0] USR = 5'b10000;
  localparam logic [4:0] SVC = 5'b10011;

  int n_run = 0;
  int n_fail = 0;

  bit       mv = 0, mx = 0, mr = 0;
  bit [3:0] mf = 0;

  always #2.5 clk = ~clk;

  cond_flag_unit i_cond_flag_unit (.*);

  function automatic bit cond_ok(input bit [3:0] c, input bit [3:0] f);
    bit n, z, cy, v;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] mk(input bit [3:0] c, input bit s, input bit [3:0] rd);
    logic [31:0] w;
    w = 32'h0;
    w[31:28] = c;
    w[20] = s;
    w[15:12] = rd;
    return w;
  endfunction

  task automatic chk(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "out_valid", {3'b0, out_valid}, {3'b0, mv});
    if (mv) begin
      chk(tag, "out_exec", {3'b0, out_exec}, {3'b0, mx});
      chk(tag, "out_restore", {3'b0, out_restore}, {3'b0, mr});
    end
    chk(tag, "flags", flags_nzcv, mf);
    chk(tag, "in_ready", {3'b0, in_ready}, {3'b0, (!mv || out_ready)});
  endtask

  // Reference model step for the edge about to come, then compare after it.
  task automatic tick(input string tag);
    bit acc, ex, rs, fw, pcd;
    bit [3:0] nf;
    acc = in_valid && (!mv || out_ready);
    if (acc) begin
      nf = mf; rs = 0;
      if (in_thumb) begin
        ex = in_tcbr ? cond_ok(in_instr[11:8], mf) : 1'b1;
        fw = ex && in_dp;
        pcd = 0;
      end else begin
        ex = cond_ok(in_instr[31:28], mf);
        fw = ex && in_dp && in_instr[20];
        pcd = (in_instr[15:12] == 4'hF);
      end
      if (fw && pcd) begin
        if (mode != USR) begin nf = saved_nzcv; rs = 1; end
      end else if (fw) begin
        nf = in_logical ? {alu_nzcv[3], alu_nzcv[2], shift_carry, mf[0]} : alu_nzcv;
      end
      mv = 1; mx = ex; mr = rs; mf = nf;
    end else if (out_ready) begin
      mv = 0;
    end
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  task automatic beat(input logic [31:0] ins, input bit th, input bit tb, input bit dp,
                      input bit lg, input bit [3:0] alu, input bit shc, input logic [4:0] md,
                      input bit [3:0] sv, input string tag);
    in_valid = 1; out_ready = 1;
    in_instr = ins; in_thumb = th; in_tcbr = tb; in_dp = dp; in_logical = lg;
    alu_nzcv = alu; shift_carry = shc; mode = md; saved_nzcv = sv;
    tick(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare("R1");
    chk("R1", "reset flags", flags_nzcv, 4'h0);
    rst_n = 1;

    // R2 / R13: set flags with an always beat, probe every code right behind it.
    for (int f = 0; f < 16; f++) begin
      for (int c = 0; c < 16; c++) begin
        beat(mk(4'hE, 1, 4'h0), 0, 0, 1, 0, 4'(f), 0, USR, 0, "R5");
        beat(mk(4'(c), 0, 4'h1), 0, 0, 0, 0, 4'h0, 0, USR, 0, "R2");
      end
    end
    beat(mk(4'hE, 1, 4'h0), 0, 0, 1, 0, 4'b0100, 0, USR, 0, "R13");
    beat(mk(4'h0, 1, 4'h2), 0, 0, 1, 0, 4'b1001, 0, USR, 0, "R13");

    // R3: flag-setting beats under every code with Z set
    for (int c = 0; c < 16; c++) begin
      beat(mk(4'hE, 1, 4'h0), 0, 0, 1, 0, 4'b0100, 0, USR, 0, "R3");
      beat(mk(4'(c), 1, 4'h3), 0, 0, 1, 0, 4'b1011, 0, USR, 0, "R3");
    end

    // R4: S clear, or not data processing
    beat(mk(4'hE, 1, 4'h0), 0, 0, 1, 0, 4'b0110, 0, USR, 0, "R5");
    beat(mk(4'hE, 0, 4'h2), 0, 0, 1, 0, 4'b1001, 1, USR, 0, "R4");
    beat(mk(4'hE, 1, 4'h2), 0, 0, 0, 0, 4'b1001, 1, USR, 0, "R4");

    // R6: logical with V preserved
    beat(mk(4'hE, 1, 4'h0), 0, 0, 1, 0, 4'b0001, 0, USR, 0, "R5");
    beat(mk(4'hE, 1, 4'h4), 0, 0, 1, 1, 4'b1110, 0, USR, 0, "R6");
    beat(mk(4'hE, 1, 4'h4), 0, 0, 1, 1, 4'b0100, 1, USR, 0, "R6");

    // R7 / R8: destination 15 with S set
    beat(mk(4'hE, 1, 4'hF), 0, 0, 1, 0, 4'b0000, 0, SVC, 4'b1010, "R7");
    beat(mk(4'hF, 1, 4'hF), 0, 0, 1, 0, 4'b0000, 0, SVC, 4'b0101, "R7");
    beat(mk(4'hE, 1, 4'hF), 0, 0, 1, 0, 4'b0011, 0, USR, 4'b0101, "R8");
    beat(mk(4'hE, 0, 4'hF), 0, 0, 1, 0, 4'b0011, 0, SVC, 4'b0101, "R7");

    // R9 / R10 / R11: compressed state
    beat(mk(4'hF, 0, 4'h0), 1, 0, 0, 0, 4'h0, 0, USR, 0, "R9");
    for (int c = 0; c < 16; c++)
      beat({16'h0, 4'hD, 4'(c), 8'h00}, 1, 1, 0, 0, 4'h0, 0, USR, 0, "R10");
    beat(mk(4'hF, 0, 4'hF), 1, 0, 1, 0, 4'b1000, 0, SVC, 4'hF, "R11");
    beat(mk(4'h0, 0, 4'h0), 1, 0, 1, 1, 4'b0101, 1, SVC, 4'hF, "R11");

    // R12: directed stall, then random traffic with back-pressure
    beat(mk(4'hE, 1, 4'h0), 0, 0, 1, 0, 4'b0110, 0, USR, 0, "R12");
    out_ready = 0;
    in_instr = mk(4'hE, 1, 4'h0); in_dp = 1; alu_nzcv = 4'b1001;
    tick("R12");
    tick("R12");
    in_instr = mk(4'h0, 1, 4'h0); alu_nzcv = 4'b0011;
    tick("R12");
    out_ready = 1;
    tick("R12");
    tick("R12");

    for (int i = 0; i < 3000; i++) begin
      in_valid    = $urandom_range(0, 3) != 0;
      out_ready   = $urandom_range(0, 1) != 0;
      in_instr    = $urandom;
      in_thumb    = $urandom_range(0, 3) == 0;
      in_tcbr     = $urandom_range(0, 1) != 0;
      in_dp       = $urandom_range(0, 1) != 0;
      in_logical  = $urandom_range(0, 1) != 0;
      alu_nzcv    = 4'($urandom);
      shift_carry = $urandom_range(0, 1) != 0;
      mode        = ($urandom_range(0, 1) != 0) ? USR : SVC;
      saved_nzcv  = 4'($urandom);
      tick("R12");
    end
    in_valid = 0; out_ready = 1;
    tick("R12");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule